// File: doc/BRIEF.md
# Register Rename Map with Per-Instruction Checkpoints

This block translates architectural register numbers into physical register numbers for one instruction per cycle. A destination register gets a fresh physical register taken from a pool of unused ones. Source registers are looked up in the current mapping. The block also reports the physical register that held the destination before this instruction, called the stale register. The caller supplies a window tag for each instruction. The tag names a slot in a 16-entry circular in-flight window, and tags are handed out in program order.

Each accepted instruction saves the whole mapping that was in effect when it was renamed. It also keeps its new and stale physical registers. When an instruction retires, its stale register goes back to the pool. When a squash names the oldest wrong-path instruction, three things happen in one cycle:

- the mapping is rolled back to that instruction's saved copy;
- every instruction from that tag up to the youngest one is dropped;
- the physical registers those dropped instructions took go back to the pool.

Top module: `reg_rename_ckpt`

## Requirements
- R1: After reset, architectural register n maps to physical register n for n = 0..15. Physical registers 16..31 are free, no window slot is in use, and `ren_ready` is high for a request on any tag.
- R2: An accepted request with `ren_has_dst` = 1 receives the lowest-numbered free physical register on `ren_phys_dst`, in the same cycle. That register differs from both source mappings and from the stale register.
- R3: `ren_phys_a` and `ren_phys_b` give the current mapping of `ren_src_a` and `ren_src_b` in the same cycle. They do not see the destination update of the instruction being renamed.
- R4: `ren_stale` gives the current mapping of `ren_dst`. From the cycle after acceptance, `ren_dst` maps to the newly allocated register.
- R5: A request with `ren_has_dst` = 0 takes no register from the pool and leaves the mapping unchanged.
- R6: `ren_ready` is low while `sq_valid` is high, while the slot named by `ren_tag` holds an in-flight instruction, or when `ren_has_dst` = 1 and the pool is empty.
- R7: A retire of an in-flight tag whose instruction had a destination returns that instruction's stale register to the pool. The register can be allocated from the next cycle.
- R8: A squash on `sq_tag` restores, from the next cycle, the mapping that was in effect just before the instruction with that tag was renamed.
- R9: A squash frees every in-flight slot from `sq_tag` up to the youngest renamed tag. The physical registers those instructions allocated can be allocated from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_tag | input | 4 | Window slot for the request |
| ren_has_dst | input | 1 | Request writes a register |
| ren_dst | input | 4 | Architectural destination |
| ren_src_a | input | 4 | Architectural source A |
| ren_src_b | input | 4 | Architectural source B |
| ren_ready | output | 1 | Request is accepted at the next edge when ren_valid is high |
| ren_phys_dst | output | 5 | Physical register allocated to the destination |
| ren_phys_a | output | 5 | Physical register of source A |
| ren_phys_b | output | 5 | Physical register of source B |
| ren_stale | output | 5 | Previous physical register of the destination |
| ret_valid | input | 1 | Retire request |
| ret_tag | input | 4 | Window slot being retired |
| sq_valid | input | 1 | Squash request |
| sq_tag | input | 4 | Oldest squashed window slot |

## Verification
All rename outputs (`ren_ready`, `ren_phys_dst`, `ren_phys_a`, `ren_phys_b`, `ren_stale`) are combinational on the current state and request. They are therefore due in the same cycle the request is driven. The effects of an accepted rename, a retire or a squash become visible one cycle after the accepting rising edge. The bench drives every stimulus just after a falling edge and samples the rename outputs 2 ns later, ahead of the next rising edge. It checks the effect of a state change only through a request made in a later cycle.

// File: rtl/rn_pkg.sv
// Package: shared sizing constants for the rename map.
// Assumes power-of-two counts. The pool holds at least as many physical
// registers as there are architectural registers plus window slots.
package rn_pkg;
    localparam int RN_NUM_ARCH  = 16;
    localparam int RN_NUM_PHYS  = 32;
    localparam int RN_WIN_DEPTH = 16;
    localparam int RN_AW        = $clog2(RN_NUM_ARCH);
    localparam int RN_PW        = $clog2(RN_NUM_PHYS);
    localparam int RN_TW        = $clog2(RN_WIN_DEPTH);
endpackage

// File: rtl/rn_free_list.sv
// Module: pool of unused physical registers, kept as one bit per register.
// Hands out the lowest-numbered free register and takes back a mask of
// released registers each cycle.
// Assumes the caller never allocates from an empty pool and never releases
// a register that is already free.
module rn_free_list #(
    parameter int NP = 32,
    parameter int NA = 16,
    localparam int PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic [NP-1:0] release_mask,
    output logic          any_free,
    output logic [PW-1:0] alloc_idx
);
    logic [NP-1:0] free_q;
    logic [NP-1:0] alloc_onehot;

    // Pick the lowest-numbered free register.
    always_comb begin
        alloc_idx = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (free_q[i]) alloc_idx = PW'(i);
        end
    end

    assign any_free     = |free_q;
    assign alloc_onehot = alloc_en ? (NP'(1) << alloc_idx) : '0;

    // Update the pool: clear the allocated bit, set the released bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) free_q[i] <= (i >= NA);
        end else begin
            free_q <= (free_q & ~alloc_onehot) | release_mask;
        end
    end

    AST_NO_DOUBLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (release_mask & free_q) == '0); // R7
    AST_ALLOC_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> any_free); // R6
endmodule

// File: rtl/rn_map_table.sv
// Module: current architectural-to-physical map plus one full map copy per
// window slot.
// Each accepted instruction saves the map in effect before its own update.
// A restore reloads the copy saved for the named slot.
// Assumes restore and write are never requested in the same cycle.
module rn_map_table #(
    parameter int NA  = 16,
    parameter int NP  = 32,
    parameter int WIN = 16,
    localparam int AW = $clog2(NA),
    localparam int PW = $clog2(NP),
    localparam int TW = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_tag,
    input  logic          wr_has_dst,
    input  logic [AW-1:0] wr_dst,
    input  logic [PW-1:0] wr_phys,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    output logic [PW-1:0] phys_a,
    output logic [PW-1:0] phys_b,
    output logic [PW-1:0] phys_old,
    input  logic          restore_en,
    input  logic [TW-1:0] restore_tag
);
    typedef logic [NA-1:0][PW-1:0] map_t;

    map_t map_q;
    map_t snap_q [WIN];

    // Look up sources and the old destination mapping.
    assign phys_a   = map_q[rd_a];
    assign phys_b   = map_q[rd_b];
    assign phys_old = map_q[wr_dst];

    // Maintain the live map: identity at reset, rollback on squash, update on rename.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NA; i++) map_q[i] <= PW'(i);
        end else if (restore_en) begin
            map_q <= snap_q[restore_tag];
        end else if (wr_en && wr_has_dst) begin
            map_q[wr_dst] <= wr_phys;
        end
    end

    // Save the pre-rename map for the accepted slot.
    always_ff @(posedge clk) begin
        if (wr_en) snap_q[wr_tag] <= map_q;
    end

    AST_RESTORE_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> map_q == $past(snap_q[restore_tag])); // R8
endmodule

// File: rtl/rn_window.sv
// Module: per-slot in-flight bookkeeping for the rename map.
// Each slot keeps its busy bit, destination flag, new register and stale
// register. The module also tracks the slot after the youngest rename, and
// it builds the mask of registers to release on retire and on squash.
// Assumes tags are allocated in circular order and retire names a busy slot.
module rn_window #(
    parameter int NP  = 32,
    parameter int WIN = 16,
    localparam int PW = $clog2(NP),
    localparam int TW = $clog2(WIN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_en,
    input  logic [TW-1:0]  alloc_tag,
    input  logic           alloc_has_dst,
    input  logic [PW-1:0]  alloc_phys,
    input  logic [PW-1:0]  alloc_stale,
    input  logic           ret_en,
    input  logic [TW-1:0]  ret_tag,
    input  logic           sq_en,
    input  logic [TW-1:0]  sq_tag,
    output logic [WIN-1:0] busy,
    output logic [NP-1:0]  release_mask
);
    logic [WIN-1:0] valid_q;
    logic [WIN-1:0] dst_q;
    logic [PW-1:0]  newp_q   [WIN];
    logic [PW-1:0]  stalep_q [WIN];
    logic [TW-1:0]  tail_q;
    logic [TW-1:0]  span;
    logic [WIN-1:0] squashed;

    assign busy = valid_q;
    assign span = tail_q - sq_tag;

    // Mark the busy slots that lie between the squash tag and the youngest rename.
    always_comb begin
        for (int i = 0; i < WIN; i++) begin
            squashed[i] = sq_en && valid_q[i] &&
                          ((span == '0) || ((TW'(i) - sq_tag) < span));
        end
    end

    // Gather registers to return: stale of the retiring slot, new of squashed slots.
    always_comb begin
        release_mask = '0;
        if (ret_en && valid_q[ret_tag] && dst_q[ret_tag] && !squashed[ret_tag])
            release_mask[stalep_q[ret_tag]] = 1'b1;
        for (int i = 0; i < WIN; i++) begin
            if (squashed[i] && dst_q[i]) release_mask[newp_q[i]] = 1'b1;
        end
    end

    // Track slot occupancy and the slot after the youngest rename.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tail_q  <= '0;
        end else begin
            for (int i = 0; i < WIN; i++) begin
                if (squashed[i]) valid_q[i] <= 1'b0;
            end
            if (ret_en) valid_q[ret_tag] <= 1'b0;
            if (alloc_en) begin
                valid_q[alloc_tag] <= 1'b1;
                tail_q             <= alloc_tag + 1'b1;
            end
            if (sq_en) tail_q <= sq_tag;
        end
    end

    // Record the register payload of the accepted slot.
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            dst_q[alloc_tag]    <= alloc_has_dst;
            newp_q[alloc_tag]   <= alloc_phys;
            stalep_q[alloc_tag] <= alloc_stale;
        end
    end

    AST_RETIRE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |-> valid_q[ret_tag]); // R7
    AST_ALLOC_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !valid_q[alloc_tag]); // R6
    AST_SQUASH_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        sq_en && !alloc_en |=> !valid_q[$past(sq_tag)]); // R9
endmodule

// File: rtl/reg_rename_ckpt.sv
// Module: top of the rename map.
// Accepts one rename request per cycle. Stalls on a busy slot, an empty
// pool or a squash. Wires together the pool, the map with its copies and
// the in-flight window.
// Assumes the caller issues tags in circular program order.
module reg_rename_ckpt
    import rn_pkg::*;
#(
    parameter int NUM_ARCH = RN_NUM_ARCH,
    parameter int NUM_PHYS = RN_NUM_PHYS,
    parameter int WIN      = RN_WIN_DEPTH,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS),
    localparam int TW = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [TW-1:0] ren_tag,
    input  logic          ren_has_dst,
    input  logic [AW-1:0] ren_dst,
    input  logic [AW-1:0] ren_src_a,
    input  logic [AW-1:0] ren_src_b,
    output logic          ren_ready,
    output logic [PW-1:0] ren_phys_dst,
    output logic [PW-1:0] ren_phys_a,
    output logic [PW-1:0] ren_phys_b,
    output logic [PW-1:0] ren_stale,
    input  logic          ret_valid,
    input  logic [TW-1:0] ret_tag,
    input  logic          sq_valid,
    input  logic [TW-1:0] sq_tag
);
    logic                any_free;
    logic                fire;
    logic [WIN-1:0]      slot_busy;
    logic [NUM_PHYS-1:0] release_mask;

    // Accept when no squash, slot idle, and a register exists if one is needed.
    assign ren_ready = !sq_valid && !slot_busy[ren_tag] && (!ren_has_dst || any_free);
    assign fire      = ren_valid && ren_ready;

    rn_free_list #(.NP(NUM_PHYS), .NA(NUM_ARCH)) u_pool (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_en     (fire && ren_has_dst),
        .release_mask (release_mask),
        .any_free     (any_free),
        .alloc_idx    (ren_phys_dst)
    );

    rn_map_table #(.NA(NUM_ARCH), .NP(NUM_PHYS), .WIN(WIN)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (fire),
        .wr_tag      (ren_tag),
        .wr_has_dst  (ren_has_dst),
        .wr_dst      (ren_dst),
        .wr_phys     (ren_phys_dst),
        .rd_a        (ren_src_a),
        .rd_b        (ren_src_b),
        .phys_a      (ren_phys_a),
        .phys_b      (ren_phys_b),
        .phys_old    (ren_stale),
        .restore_en  (sq_valid),
        .restore_tag (sq_tag)
    );

    rn_window #(.NP(NUM_PHYS), .WIN(WIN)) u_win (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_en      (fire),
        .alloc_tag     (ren_tag),
        .alloc_has_dst (ren_has_dst),
        .alloc_phys    (ren_phys_dst),
        .alloc_stale   (ren_stale),
        .ret_en        (ret_valid),
        .ret_tag       (ret_tag),
        .sq_en         (sq_valid),
        .sq_tag        (sq_tag),
        .busy          (slot_busy),
        .release_mask  (release_mask)
    );

    AST_DST_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        fire && ren_has_dst |-> (ren_phys_dst != ren_phys_a) &&
        (ren_phys_dst != ren_phys_b) && (ren_phys_dst != ren_stale)); // R2
endmodule

// File: tb/reg_rename_ckpt_tb_top.sv
module reg_rename_ckpt_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ren_valid, ren_has_dst, ren_ready;
    logic [3:0] ren_tag, ren_dst, ren_src_a, ren_src_b;
    logic [4:0] ren_phys_dst, ren_phys_a, ren_phys_b, ren_stale;
    logic       ret_valid, sq_valid;
    logic [3:0] ret_tag, sq_tag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    reg_rename_ckpt dut_i (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_tag(ren_tag), .ren_has_dst(ren_has_dst),
        .ren_dst(ren_dst), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_ready(ren_ready), .ren_phys_dst(ren_phys_dst),
        .ren_phys_a(ren_phys_a), .ren_phys_b(ren_phys_b), .ren_stale(ren_stale),
        .ret_valid(ret_valid), .ret_tag(ret_tag),
        .sq_valid(sq_valid), .sq_tag(sq_tag)
    );

    // Fields: has_dst | dst | src_a | src_b | exp_dst | exp_a | exp_b | exp_stale
    localparam logic [32:0] VEC [5] = '{
        {1'b1, 4'd1,  4'd2,  4'd3, 5'd16, 5'd2,  5'd3,  5'd1},
        {1'b1, 4'd2,  4'd1,  4'd1, 5'd17, 5'd16, 5'd16, 5'd2},
        {1'b0, 4'd0,  4'd2,  4'd1, 5'd0,  5'd17, 5'd16, 5'd0},
        {1'b1, 4'd1,  4'd1,  4'd0, 5'd18, 5'd16, 5'd0,  5'd16},
        {1'b1, 4'd15, 4'd15, 4'd2, 5'd19, 5'd15, 5'd17, 5'd15}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ren_valid = 0; ren_has_dst = 0; ren_tag = 0; ren_dst = 0;
        ren_src_a = 0; ren_src_b = 0;
        ret_valid = 0; ret_tag = 0; sq_valid = 0; sq_tag = 0;
    endtask

    // Drive a rename request just after a falling edge and let outputs settle.
    task automatic req(input int tag, input bit hd, input int dst, input int sa, input int sb);
        ren_valid = 1; ren_tag = 4'(tag); ren_has_dst = hd;
        ren_dst = 4'(dst); ren_src_a = 4'(sa); ren_src_b = 4'(sb);
        #2;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        do_reset();
        // R1 reset state, R2 first allocation
        ren_valid = 0; ren_has_dst = 1; ren_tag = 0; ren_src_a = 5; ren_src_b = 0;
        #2;
        check("R1 ready", ren_ready, 1);
        check("R1 map r5", ren_phys_a, 5);
        check("R1 map r0", ren_phys_b, 0);
        check("R2 first free", ren_phys_dst, 16);
        idle();

        // Vector table walk, tags 0..4
        for (int v = 0; v < 5; v++) begin
            req(v, VEC[v][32], VEC[v][31:28], VEC[v][27:24], VEC[v][23:20]);
            check("R6 ready", ren_ready, 1);
            check("R3 src a", ren_phys_a, VEC[v][14:10]);
            check("R3 src b", ren_phys_b, VEC[v][9:5]);
            if (VEC[v][32]) begin
                check("R2 dst", ren_phys_dst, VEC[v][19:15]);
                check("R4 stale", ren_stale, VEC[v][4:0]);
            end
            step();
        end

        // R6 busy slot stalls even without a destination
        req(1, 0, 0, 0, 0);
        check("R6 busy slot", ren_ready, 0);
        step();

        // Squash from tag 3; R6 stall during squash
        sq_valid = 1; sq_tag = 3;
        req(5, 1, 7, 0, 0);
        check("R6 squash stall", ren_ready, 0);
        step();
        req(3, 1, 4, 1, 15);
        check("R8 r1 restored", ren_phys_a, 16);
        check("R8 r15 restored", ren_phys_b, 15);
        check("R9 reclaimed", ren_phys_dst, 18);
        check("R4 stale r4", ren_stale, 4);
        step();

        // R7 retire tag 0 returns physical 1
        ret_valid = 1; ret_tag = 0;
        step();
        req(4, 1, 5, 4, 0);
        check("R7 stale reused", ren_phys_dst, 1);
        check("R4 r4 remapped", ren_phys_a, 18);
        step();

        // R5 no destination takes nothing
        req(5, 0, 6, 5, 0);
        check("R5 map r5", ren_phys_a, 1);
        step();
        req(6, 1, 6, 6, 0);
        check("R5 pool untouched", ren_phys_dst, 19);
        check("R5 r6 unchanged", ren_stale, 6);
        step();

        // Fill the whole window and pool after a fresh reset
        do_reset();
        for (int t = 0; t < 16; t++) begin
            req(t, 1, t, t, 0);
            check("R2 fill", ren_phys_dst, 16 + t);
            step();
        end
        req(0, 1, 0, 0, 0);
        check("R6 pool empty", ren_ready, 0);
        idle();

        // Squash tags 8..15 of a full window
        sq_valid = 1; sq_tag = 8;
        step();
        req(8, 1, 3, 9, 7);
        check("R8 r9 restored", ren_phys_a, 9);
        check("R8 r7 kept", ren_phys_b, 23);
        check("R9 full squash", ren_phys_dst, 24);
        check("R4 stale r3", ren_stale, 19);
        step();
        req(9, 1, 0, 0, 0);
        check("R9 next reclaimed", ren_phys_dst, 25);
        step();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule